// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Wrap Order

This block produces the array address for a synchronous memory that supports short bursts. On a load cycle it captures a complete external address. On each following advance cycle it moves to the next word of a four-word group by changing only the two lowest address bits. The upper bits stay fixed for the whole burst.

A static order-select input picks one of two wrap orders over the low bits. Interleaved order combines the start offset with a running step count by exclusive-or. Linear order adds the step count to the start offset modulo four. A hold input freezes the address and the burst position for as many cycles as it stays high. After four steps the burst comes back to its start word and keeps cycling for as long as advance stays high.

The output comes from registers through a small combinational offset stage. It changes in the cycle after the clock edge that samples the inputs. Command decoding, chip selection and data movement are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the first load or advance, `addr_o` is all zeros and the burst position is zero.
- R2: On a clock edge with `hold_i`=0 and `adv_i`=0, the whole of `ext_addr_i` is captured. From the next cycle `addr_o` equals it, and that word is position 0 of a new burst.
- R3: On a clock edge with `hold_i`=1, neither the captured address nor the burst position changes, whatever `adv_i` and `ext_addr_i` carry.
- R4: With `order_sel_i`=1 (interleaved), the low two bits of `addr_o` at burst position k are the start offset XOR k. From 00 the sequence is 00,01,10,11; from 01 it is 01,00,11,10; from 10 it is 10,11,00,01; from 11 it is 11,10,01,00.
- R5: With `order_sel_i`=0 (linear), the low two bits at burst position k are (start offset + k) mod 4. From 01 the sequence is 01,10,11,00; from 10 it is 10,11,00,01; from 11 it is 11,00,01,10.
- R6: On an advance edge (`hold_i`=0, `adv_i`=1), `addr_o[18:2]` keeps its value and `ext_addr_i` has no effect.
- R7: Each advance edge moves the burst position up by one modulo 4. After four advances `addr_o` is back at the start word, and the cycle repeats while advance continues.
- R8: A load issued in the middle of a burst discards the old burst and starts again at position 0 with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | 1 = freeze address and burst position on this edge |
| adv_i | input | 1 | 1 = advance the burst, 0 = load `ext_addr_i` |
| ext_addr_i | input | 19 | External address, captured on load edges |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | 19 | Current array address |

## Verification
The hardest condition to reach is a wrap that happens between other events. That means a burst reaching its fifth word after a hold, or a new load landing at an arbitrary point in a running burst, with the start offset and order varied on each side. The stimulus runs every start offset in both orders past the wrap point. It inserts hold cycles in the middle of bursts, with the advance and address inputs set to conflicting values. It reloads at positions 1, 2 and 3. A behavioural model in the bench tracks each of these sequences and compares `addr_o` on every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } burst_op_e;

  function automatic burst_op_e classify_op(input logic hold, input logic adv);
    burst_op_e op;
    if (hold)      op = OP_HOLD;
    else if (!adv) op = OP_LOAD;
    else           op = OP_STEP;
    return op;
  endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic hold_i,
  input  logic adv_i,
  output logic load_evt,
  output logic step_evt,
  output logic hold_evt
);
  burst_op_e op;

  always_comb begin
    op       = classify_op(hold_i, adv_i);
    load_evt = (op == OP_LOAD);
    step_evt = (op == OP_STEP);
    hold_evt = (op == OP_HOLD);
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W  = 19,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         ext_addr,
  output logic [ADDR_W-BURST_W-1:0] base_hi,
  output logic [BURST_W-1:0]        start_ofs
);
  localparam int HI_W = ADDR_W - BURST_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= '0;
      start_ofs <= '0;
    end else if (load) begin
      base_hi   <= ext_addr[ADDR_W-1:BURST_W];
      start_ofs <= ext_addr[BURST_W-1:0];
    end
  end

  initial begin
    if (HI_W < 1) $error("burst_base_reg: BURST_W must be below ADDR_W");
  end
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  output logic [BURST_W-1:0] step_cnt
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_cnt <= '0;
    else if (load)  step_cnt <= '0;
    else if (step)  step_cnt <= step_cnt + ONE;
  end
endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_ofs,
  input  logic [BURST_W-1:0] step_cnt,
  input  logic               order_sel,
  output logic [BURST_W-1:0] offset
);
  logic [BURST_W-1:0] ilv_ofs;
  logic [BURST_W-1:0] lin_ofs;
  logic [BURST_W:0]   carry;

  assign carry[0] = 1'b0;

  genvar b;
  generate
    for (b = 0; b < BURST_W; b++) begin : g_bit
      assign ilv_ofs[b]  = start_ofs[b] ^ step_cnt[b];
      assign lin_ofs[b]  = start_ofs[b] ^ step_cnt[b] ^ carry[b];
      assign carry[b+1]  = (start_ofs[b] & step_cnt[b]) |
                           (carry[b] & (start_ofs[b] ^ step_cnt[b]));
    end
  endgenerate

  burst_order_e order;
  assign order  = burst_order_e'(order_sel);
  assign offset = (order == ORDER_INTERLEAVED) ? ilv_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W  = 19,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               load_evt;
  logic               step_evt;
  logic               hold_evt;
  logic [HI_W-1:0]    base_hi;
  logic [BURST_W-1:0] start_ofs;
  logic [BURST_W-1:0] step_cnt;
  logic [BURST_W-1:0] offset;

  burst_cmd_decode u_dec (
    .hold_i   (hold_i),
    .adv_i    (adv_i),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .hold_evt (hold_evt)
  );

  burst_base_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .ext_addr  (ext_addr_i),
    .base_hi   (base_hi),
    .start_ofs (start_ofs)
  );

  burst_step_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .step     (step_evt),
    .step_cnt (step_cnt)
  );

  burst_offset_gen #(.BURST_W(BURST_W)) u_ofs (
    .start_ofs (start_ofs),
    .step_cnt  (step_cnt),
    .order_sel (order_sel_i),
    .offset    (offset)
  );

  assign addr_o = {base_hi, offset};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 19,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              load_evt,
  input logic              step_evt,
  input logic              hold_evt,
  input logic [BURST_W-1:0] step_cnt
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_o == $past(ext_addr_i))); // R2

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (step_cnt == '0)); // R8

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> ($stable(step_cnt) && (!$stable(order_sel_i) || $stable(addr_o)))); // R3

  AST_HOLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> hold_evt); // R3

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]))); // R6

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (step_cnt - $past(step_cnt) == BURST_W'(1))); // R7

  AST_LINEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_sel_i) |=>
      (order_sel_i || (addr_o[BURST_W-1:0] - $past(addr_o[BURST_W-1:0]) == BURST_W'(1)))); // R5

  AST_INTERLEAVE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_sel_i) |=>
      (!order_sel_i || ((addr_o[BURST_W-1:0] ^ $past(addr_o[BURST_W-1:0])) ==
                        (step_cnt ^ $past(step_cnt))))); // R4

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (addr_o == '0); // R1
  end
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_i      (hold_i),
  .ext_addr_i  (ext_addr_i),
  .order_sel_i (order_sel_i),
  .addr_o      (addr_o),
  .load_evt    (load_evt),
  .step_evt    (step_evt),
  .hold_evt    (hold_evt),
  .step_cnt    (step_cnt)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          order_sel_i = 1'b1;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int unsigned m_base = 0;
  int unsigned m_pos  = 0;
  int unsigned seq_ilv[$];
  int unsigned seq_lin[$];

  always #4 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i),
    .ext_addr_i(ext_addr_i), .order_sel_i(order_sel_i), .addr_o(addr_o)
  );

  task automatic build_seqs(input int unsigned s);
    seq_ilv.delete();
    seq_lin.delete();
    for (int j = 0; j < 4; j++) begin
      seq_ilv.push_back(s ^ j);
      seq_lin.push_back((s + j) % 4);
    end
  endtask

  function automatic logic [AW-1:0] model_addr(input bit mode);
    int unsigned o;
    o = mode ? seq_ilv[m_pos] : seq_lin[m_pos];
    return AW'(m_base + o);
  endfunction

  task automatic compare(input string tag);
    logic [AW-1:0] exp;
    exp = model_addr(order_sel_i);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected %h", tag, addr_o, exp);
    end
  endtask

  // called at a negedge: drive, take one edge, update model, compare at next negedge
  task automatic cycle(input bit adv, input bit hold, input logic [AW-1:0] a,
                       input bit mode, input string tag);
    adv_i = adv; hold_i = hold; ext_addr_i = a; order_sel_i = mode;
    @(posedge clk);
    if (!hold) begin
      if (!adv) begin
        m_base = int'(a) & ~32'd3;
        build_seqs(int'(a) & 3);
        m_pos = 0;
      end else begin
        m_pos = (m_pos + 1) % 4;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic burst(input logic [AW-1:0] a, input bit mode, input int n, input string tag);
    cycle(1'b0, 1'b0, a, mode, tag);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, ~a, mode, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    build_seqs(0);
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    adv_i = 1'b1; ext_addr_i = 19'h7FFFF;
    @(negedge clk);
    compare("R1 in reset with advance");
    rst_n = 1'b1;
    hold_i = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // advance straight out of reset: R4 from 00, R7
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 19'h5A5A5, 1'b1, "R4 R7 from reset");

    // every start offset in interleaved order, beyond the wrap (R2 R4 R6 R7)
    burst(19'h12340, 1'b1, 6, "R4 start00");
    burst(19'h2ABC5, 1'b1, 6, "R4 R6 start01");
    burst(19'h0F0F2, 1'b1, 6, "R4 start10");
    burst(19'h7FFFF, 1'b1, 9, "R4 R7 start11");

    // linear order (R5)
    burst(19'h11110, 1'b0, 6, "R5 start00");
    burst(19'h22221, 1'b0, 6, "R5 start01");
    burst(19'h33332, 1'b0, 6, "R5 start10");
    burst(19'h44443, 1'b0, 9, "R5 R7 start11");

    // direct literal checks of one documented sequence each (R4 R5)
    cycle(1'b0, 1'b0, 19'h00001, 1'b1, "R2 load 01");
    cycle(1'b1, 1'b0, 19'h0, 1'b1, "R4 step");
    checks++; if (addr_o !== 19'h00000) begin errors++; $display("FAIL R4: addr_o=%h expected %h", addr_o, 19'h0); end
    cycle(1'b1, 1'b0, 19'h0, 1'b1, "R4 step");
    checks++; if (addr_o !== 19'h00003) begin errors++; $display("FAIL R4: addr_o=%h expected %h", addr_o, 19'h3); end
    cycle(1'b0, 1'b0, 19'h00003, 1'b0, "R2 load 11");
    cycle(1'b1, 1'b0, 19'h0, 1'b0, "R5 step");
    checks++; if (addr_o !== 19'h00000) begin errors++; $display("FAIL R5: addr_o=%h expected %h", addr_o, 19'h0); end

    // hold in mid-burst with conflicting inputs (R3)
    for (int m = 0; m < 2; m++) begin
      cycle(1'b0, 1'b0, 19'h3C3C1, bit'(m), "R2 load before hold");
      cycle(1'b1, 1'b0, 19'h0, bit'(m), "R3 step");
      cycle(1'b0, 1'b1, 19'h55555, bit'(m), "R3 hold with load request");
      cycle(1'b1, 1'b1, 19'h2AAAA, bit'(m), "R3 hold with advance request");
      cycle(1'b1, 1'b1, 19'h00000, bit'(m), "R3 hold");
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 19'h7FFFF, bit'(m), "R3 R7 resume");
    end

    // reload at positions 1, 2, 3 (R8)
    for (int p = 1; p < 4; p++) begin
      burst(19'h60000 + AW'(p), 1'b1, p, "R8 first burst");
      burst(19'h0ABC0 + AW'(3 - p), 1'b0, 5, "R8 reload");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule